// File: doc/BRIEF.md
# Translation Context Register Bank

This block holds the software-visible configuration and fault state of a small I/O address translation unit that serves four translation contexts. Each context has its own register window with a control word, a table-walk configuration word, a walk bus selection, a 40-bit translation table base split over two words, two memory attribute words, a fault status word and a fault address word. A 32-bit register port gives software access. The same registers can also be reached through a second, aliased address window.

On the hardware side, the block drives a flush request per context to an invalidation engine and waits for that engine's one-cycle acknowledge. A table walker reports faults by giving a context number, the fault flags, an error code and level, and the faulting address. The block keeps the first fault of each context until software clears it. It raises one interrupt line while any context that has interrupts enabled holds a fault. The translation enable and table base of each context are driven out to the walker.

Top module: `xlat_ctx_regs`

## Requirements
- R1: After reset every register reads zero, `flush_req`, `ctx_mmu_en` and `ctx_ttb` are all zero, and `irq` is low.
- R2: Context n's window starts at byte address n*0x40, and the word index is address bits 5:2. Address bit 11 is ignored, so address A and A+0x800 reach the same register. An access is ignored (writes have no effect, reads return zero) when address bits 10:8 are nonzero or bits 1:0 are nonzero. Word indexes with no register also read zero.
- R3: The control word (word 0) keeps only bits 17,16,5,4,3,2,1,0. Its other bits read zero. Bit 0 drives `ctx_mmu_en` for that context, and bit 2 is the interrupt enable.
- R4: Writing 1 to control bit 1 sets the flush request, which is seen on `flush_req` and read back in bit 1. Writing 0 to that bit leaves it unchanged. The bit clears on the clock edge where `flush_ack` for that context is high.
- R5: Word 4 is the low 32 bits of the table base. Word 5 keeps bits 7:0 as base bits 39:32 and reads zero above them. `ctx_ttb` carries the 40-bit base of each context, context n at bits 40n+39:40n.
- R6: Word 3, the bus select, keeps bits 2:0: bits 1:0 choose the walk bus and bit 2 is the coherent-broadcast enable. Words 2, 10 and 11 are full 32-bit read/write words.
- R7: A fault report (`fault_valid` high, with at least one bit of `fault_flags` set, into a context that holds no fault) is captured. `fault_flags` bits 3:0 are {multi-hit, walk abort, page fault, translation fault}. They appear in status word 8 at bits 4, 2, 1 and 0. The code appears at bits 10:8 and the level at bits 13:12. The address is captured into word 12, which is read-only. A report with no flag set is ignored.
- R8: While a context holds a fault, later reports leave its status and address unchanged. After a clear, the next report is captured.
- R9: A write of exactly zero to the status word clears the status and the fault address to zero. A nonzero write has no effect.
- R10: `irq` is high exactly while some context has its interrupt enable set and holds a fault.
- R11: A fault report or a clear changes only the addressed context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_req | input | 1 | Register access strobe |
| sw_we | input | 1 | 1 = write, 0 = read |
| sw_addr | input | 12 | Byte address of the access |
| sw_wdata | input | 32 | Write data |
| sw_rdata | output | 32 | Read data, valid in the same cycle as a read strobe |
| flush_req | output | 4 | Per-context invalidation request |
| flush_ack | input | 4 | Per-context invalidation done, one-cycle pulse |
| fault_valid | input | 1 | Fault report strobe from the walker |
| fault_ctx | input | 2 | Context of the fault report |
| fault_flags | input | 4 | {multi-hit, walk abort, page fault, translation fault} |
| fault_code | input | 3 | Error code of the fault |
| fault_level | input | 2 | Table level of the fault |
| fault_addr | input | 32 | Faulting input address |
| ctx_mmu_en | output | 4 | Per-context translation enable |
| ctx_ttb | output | 160 | Per-context 40-bit table base |
| irq | output | 1 | Fault interrupt |

## Verification
The main register path is driven from a table of writes. Each write is read back through the opposite window, which tells a correct alias decode apart from one that honours bit 11. Its patterns of all ones show which bits each register keeps. Writes to out-of-range and unaligned addresses, followed by reads of the context they would corrupt, tell a full decode apart from one that looks only at the low bits. Fault sequences first report into a clear context, then into a context that already holds a fault, then into a neighbouring context, and then with no flags. After that the status is written nonzero and then zero. These steps tell apart first-fault retention, write-zero clearing, per-context isolation and the interrupt gating. The flush is written 1, then 0, and then acknowledged after a fixed delay, which tells a held request from one that software can drop.

// File: rtl/xlat_ctx_pkg.sv
`timescale 1ns/1ps
package xlat_ctx_pkg;

  // word index within a context window (address bits 5:2)
  localparam logic [3:0] W_CTL   = 4'd0;
  localparam logic [3:0] W_TCFG  = 4'd2;
  localparam logic [3:0] W_BUS   = 4'd3;
  localparam logic [3:0] W_TTBL  = 4'd4;
  localparam logic [3:0] W_TTBH  = 4'd5;
  localparam logic [3:0] W_FSTS  = 4'd8;
  localparam logic [3:0] W_ATTR0 = 4'd10;
  localparam logic [3:0] W_ATTR1 = 4'd11;
  localparam logic [3:0] W_FADDR = 4'd12;

  localparam logic [31:0] CTL_KEEP  = 32'h0003_003F;
  localparam int          FLUSH_BIT = 1;
  localparam int          INTEN_BIT = 2;
  localparam int          MMUEN_BIT = 0;

  // flags: {multi-hit, walk abort, page fault, translation fault}
  typedef struct packed {
    logic [1:0] lvl;
    logic [2:0] code;
    logic [3:0] flags;
  } fault_rec_t;

  function automatic logic [31:0] pack_status(input fault_rec_t r);
    return {18'd0, r.lvl, 1'b0, r.code, 3'd0, r.flags[3], 1'b0, r.flags[2:0]};
  endfunction

  function automatic logic [31:0] ctl_merge(input logic [31:0] wdata);
    return wdata & CTL_KEEP & ~(32'd1 << FLUSH_BIT);
  endfunction

endpackage

// File: rtl/xlat_addr_dec.sv
`timescale 1ns/1ps
module xlat_addr_dec #(
  parameter int NUM_CTX   = 4,
  parameter int SPAN_LOG2 = 6,
  parameter int ALIAS_BIT = 11,
  parameter int ADDR_W    = 12,
  localparam int CTX_W    = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
  localparam int WIN_BITS = SPAN_LOG2 + CTX_W
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic               hit,
  output logic [CTX_W-1:0]   ctx,
  output logic [3:0]         word,
  output logic [NUM_CTX-1:0] sel
);

  logic unused_alias;

  always_comb begin
    ctx  = addr[WIN_BITS-1:SPAN_LOG2];
    word = addr[5:2];
    hit  = (addr[1:0] == 2'b00) &&
           (addr[ALIAS_BIT-1:WIN_BITS] == '0) &&
           (int'(ctx) < NUM_CTX);
    unused_alias = addr[ALIAS_BIT];
    for (int i = 0; i < NUM_CTX; i++)
      sel[i] = hit && (int'(ctx) == i);
  end

  // R2: a decoded access reaches at most one context
  always_comb a_r2_single_ctx: assert ($onehot0(sel));

endmodule

// File: rtl/xlat_ctx_slice.sv
`timescale 1ns/1ps
module xlat_ctx_slice
  import xlat_ctx_pkg::*;
#(
  parameter int PA_W = 40,
  localparam int HI_W = PA_W - 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [3:0]      word,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  input  logic            flush_ack,
  output logic            flush_req,
  input  logic            fault_in,
  input  fault_rec_t      fault_rec,
  input  logic [31:0]     fault_addr,
  output logic            mmu_en,
  output logic            int_en,
  output logic            pend,
  output logic [PA_W-1:0] ttb
);

  logic [31:0]     ctl_q;
  logic            flush_q;
  logic [31:0]     tcfg_q, attr0_q, attr1_q, ttbl_q, faddr_q;
  logic [2:0]      bus_q;
  logic [HI_W-1:0] ttbh_q;
  fault_rec_t      rec_q;

  // named events for the assertions
  logic wr_ctl, set_flush, clr_sts, new_fault, take_fault;

  always_comb begin
    wr_ctl     = wr_en && (word == W_CTL);
    set_flush  = wr_ctl && wdata[FLUSH_BIT];
    clr_sts    = wr_en && (word == W_FSTS) && (wdata == 32'd0);
    new_fault  = fault_in && (fault_rec.flags != 4'd0);
    pend       = (rec_q.flags != 4'd0);
    take_fault = new_fault && (!pend || clr_sts);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      flush_q <= 1'b0;
      tcfg_q  <= '0;
      attr0_q <= '0;
      attr1_q <= '0;
      ttbl_q  <= '0;
      ttbh_q  <= '0;
      bus_q   <= '0;
      faddr_q <= '0;
      rec_q   <= '0;
    end else begin
      if (wr_ctl) ctl_q <= ctl_merge(wdata);
      if (set_flush)      flush_q <= 1'b1;
      else if (flush_ack) flush_q <= 1'b0;
      if (wr_en) begin
        case (word)
          W_TCFG:  tcfg_q  <= wdata;
          W_BUS:   bus_q   <= wdata[2:0];
          W_TTBL:  ttbl_q  <= wdata;
          W_TTBH:  ttbh_q  <= wdata[HI_W-1:0];
          W_ATTR0: attr0_q <= wdata;
          W_ATTR1: attr1_q <= wdata;
          default: ;
        endcase
      end
      if (take_fault) begin
        rec_q   <= fault_rec;
        faddr_q <= fault_addr;
      end else if (clr_sts) begin
        rec_q   <= '0;
        faddr_q <= '0;
      end
    end
  end

  always_comb begin
    case (word)
      W_CTL:   rdata = ctl_q | (32'(flush_q) << FLUSH_BIT);
      W_TCFG:  rdata = tcfg_q;
      W_BUS:   rdata = {29'd0, bus_q};
      W_TTBL:  rdata = ttbl_q;
      W_TTBH:  rdata = {{(32-HI_W){1'b0}}, ttbh_q};
      W_FSTS:  rdata = pack_status(rec_q);
      W_ATTR0: rdata = attr0_q;
      W_ATTR1: rdata = attr1_q;
      W_FADDR: rdata = faddr_q;
      default: rdata = 32'd0;
    endcase
  end

  assign flush_req = flush_q;
  assign mmu_en    = ctl_q[MMUEN_BIT];
  assign int_en    = ctl_q[INTEN_BIT];
  assign ttb       = {ttbh_q, ttbl_q};

  // R4: a pending flush survives until acknowledged
  a_r4_flush_held: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_q && !flush_ack) |=> flush_q);

  // R4: an acknowledge with no new request drops the flush
  a_r4_flush_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_ack && !set_flush) |=> !flush_q);

  // R8: a held fault is not overwritten
  a_r8_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr_sts) |=> ($stable(faddr_q) && $stable(rec_q)));

  // R9: a zero write with no competing report empties the record
  a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_sts && !new_fault) |=> (!pend && faddr_q == 32'd0));

endmodule

// File: rtl/xlat_ctx_regs.sv
`timescale 1ns/1ps
module xlat_ctx_regs
  import xlat_ctx_pkg::*;
#(
  parameter int NUM_CTX   = 4,
  parameter int PA_W      = 40,
  parameter int ADDR_W    = 12,
  parameter int SPAN_LOG2 = 6,
  parameter int ALIAS_BIT = 11,
  localparam int CTX_W    = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sw_req,
  input  logic                    sw_we,
  input  logic [ADDR_W-1:0]       sw_addr,
  input  logic [31:0]             sw_wdata,
  output logic [31:0]             sw_rdata,
  output logic [NUM_CTX-1:0]      flush_req,
  input  logic [NUM_CTX-1:0]      flush_ack,
  input  logic                    fault_valid,
  input  logic [CTX_W-1:0]        fault_ctx,
  input  logic [3:0]              fault_flags,
  input  logic [2:0]              fault_code,
  input  logic [1:0]              fault_level,
  input  logic [31:0]             fault_addr,
  output logic [NUM_CTX-1:0]      ctx_mmu_en,
  output logic [NUM_CTX*PA_W-1:0] ctx_ttb,
  output logic                    irq
);

  logic               dec_hit;
  logic [CTX_W-1:0]   dec_ctx;
  logic [3:0]         dec_word;
  logic [NUM_CTX-1:0] dec_sel;
  logic [31:0]        slice_rd [NUM_CTX];
  logic [NUM_CTX-1:0] pend_w, inten_w;
  fault_rec_t         rec_in;

  assign rec_in = '{lvl: fault_level, code: fault_code, flags: fault_flags};

  xlat_addr_dec #(
    .NUM_CTX(NUM_CTX), .SPAN_LOG2(SPAN_LOG2),
    .ALIAS_BIT(ALIAS_BIT), .ADDR_W(ADDR_W)
  ) u_dec (
    .addr(sw_addr), .hit(dec_hit), .ctx(dec_ctx),
    .word(dec_word), .sel(dec_sel)
  );

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
    xlat_ctx_slice #(.PA_W(PA_W)) u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (sw_req && sw_we && dec_sel[g]),
      .word      (dec_word),
      .wdata     (sw_wdata),
      .rdata     (slice_rd[g]),
      .flush_ack (flush_ack[g]),
      .flush_req (flush_req[g]),
      .fault_in  (fault_valid && (int'(fault_ctx) == g)),
      .fault_rec (rec_in),
      .fault_addr(fault_addr),
      .mmu_en    (ctx_mmu_en[g]),
      .int_en    (inten_w[g]),
      .pend      (pend_w[g]),
      .ttb       (ctx_ttb[g*PA_W +: PA_W])
    );
  end

  always_comb begin
    sw_rdata = 32'd0;
    if (sw_req && !sw_we && dec_hit)
      sw_rdata = slice_rd[dec_ctx];
  end

  assign irq = |(pend_w & inten_w);

  // R10: the interrupt never rises without a held fault
  a_r10_irq_needs_fault: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend_w != '0));

  // R11: a report into one context leaves the others' records alone
  a_r11_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && fault_ctx != '0 && pend_w[0]) |=> pend_w[0]);

endmodule

// File: tb/xlat_ctx_regs_bench.sv
`timescale 1ns/1ps
module xlat_ctx_regs_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sw_req = 1'b0, sw_we = 1'b0;
  logic [11:0]  sw_addr = '0;
  logic [31:0]  sw_wdata = '0;
  logic [31:0]  sw_rdata;
  logic [3:0]   flush_req;
  logic [3:0]   flush_ack = '0;
  logic         fault_valid = 1'b0;
  logic [1:0]   fault_ctx = '0;
  logic [3:0]   fault_flags = '0;
  logic [2:0]   fault_code = '0;
  logic [1:0]   fault_level = '0;
  logic [31:0]  fault_addr = '0;
  logic [3:0]   ctx_mmu_en;
  logic [159:0] ctx_ttb;
  logic         irq;

  int total = 0;
  int bad   = 0;
  localparam int ACK_LAT = 3;

  always #2.5 clk = ~clk;

  xlat_ctx_regs u_xlat_ctx_regs (
    .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_we(sw_we),
    .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .flush_req(flush_req), .flush_ack(flush_ack),
    .fault_valid(fault_valid), .fault_ctx(fault_ctx),
    .fault_flags(fault_flags), .fault_code(fault_code),
    .fault_level(fault_level), .fault_addr(fault_addr),
    .ctx_mmu_en(ctx_mmu_en), .ctx_ttb(ctx_ttb), .irq(irq)
  );

  // {address, write data, expected read-back through the other window}
  localparam logic [95:0] VEC [0:9] = '{
    {32'h000, 32'hFFFF_FFFD, 32'h0003_003D},  // R3 ctx0 control
    {32'h04C, 32'hFFFF_FFFF, 32'h0000_0007},  // R6 ctx1 bus select
    {32'h090, 32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R5 ctx2 base low
    {32'h094, 32'h1234_56A5, 32'h0000_00A5},  // R5 ctx2 base high
    {32'h0C8, 32'h8000_3515, 32'h8000_3515},  // R6 ctx3 walk config
    {32'h028, 32'h0044_FF04, 32'h0044_FF04},  // R6 ctx0 attr 0
    {32'h0EC, 32'hCAFE_F00D, 32'hCAFE_F00D},  // R6 ctx3 attr 1
    {32'h004, 32'hFFFF_FFFF, 32'h0000_0000},  // R2 empty word
    {32'h100, 32'hFFFF_FFFF, 32'h0000_0000},  // R2 beyond contexts
    {32'h070, 32'h0000_1234, 32'h0000_0000}   // R7 fault address read-only
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    sw_req = 1'b1; sw_we = 1'b1; sw_addr = a; sw_wdata = d;
    @(negedge clk);
    sw_req = 1'b0; sw_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    sw_req = 1'b1; sw_we = 1'b0; sw_addr = a;
    #1 v = sw_rdata;
    sw_req = 1'b0;
  endtask

  task automatic fault(input logic [1:0] c, input logic [3:0] f, input logic [2:0] code,
                       input logic [1:0] lvl, input logic [31:0] a);
    @(negedge clk);
    fault_valid = 1'b1; fault_ctx = c; fault_flags = f;
    fault_code = code; fault_level = lvl; fault_addr = a;
    @(negedge clk);
    fault_valid = 1'b0;
  endtask

  task automatic ack(input int c);
    repeat (ACK_LAT) @(negedge clk);
    flush_ack[c] = 1'b1;
    @(negedge clk);
    flush_ack[c] = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(12'h000, v); chk("R1 ctl", v, 0);
    rd(12'h0E0, v); chk("R1 status", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 flush_req", flush_req, 0);
    chk("R1 ttb", ctx_ttb, 0);

    // table walk: write, read back through the alias window (R2)
    for (int i = 0; i < 10; i++) begin
      wr(VEC[i][75:64], VEC[i][63:32]);
      rd(VEC[i][75:64] ^ 12'h800, v);
      chk($sformatf("R2 vec%0d", i), v, VEC[i][31:0]);
    end
    rd(12'h000, v); chk("R2 ctx0 untouched by 0x100", v, 32'h0003_003D);
    wr(12'h002, 32'h0);
    rd(12'h000, v); chk("R2 unaligned write ignored", v, 32'h0003_003D);
    rd(12'h001, v); chk("R2 unaligned read zero", v, 0);
    chk("R5 ttb ctx2", ctx_ttb[80 +: 40], 40'hA5_DEAD_BEEF);
    chk("R3 mmu_en", ctx_mmu_en, 4'b0001);

    // R4 flush handshake on ctx1
    wr(12'h040, 32'h2);
    chk("R4 flush_req set", flush_req, 4'b0010);
    rd(12'h840, v); chk("R4 flush reads 1", v, 32'h2);
    wr(12'h040, 32'h5);
    rd(12'h040, v); chk("R4 zero write keeps flush", v, 32'h7);
    ack(1);
    chk("R4 flush_req dropped", flush_req, 0);
    rd(12'h040, v); chk("R4 flush bit cleared", v, 32'h5);
    chk("R3 mmu_en ctx1", ctx_mmu_en, 4'b0011);

    // R7 fault capture on ctx1 (interrupt enabled)
    fault(2'd1, 4'b0010, 3'd4, 2'd2, 32'h4000_1234);
    rd(12'h060, v); chk("R7 status", v, 32'h0000_2402);
    rd(12'h070, v); chk("R7 address", v, 32'h4000_1234);
    chk("R10 irq raised", irq, 1);

    // R8 second fault ignored
    fault(2'd1, 4'b1000, 3'd5, 2'd3, 32'h0000_5555);
    rd(12'h060, v); chk("R8 status kept", v, 32'h0000_2402);
    rd(12'h070, v); chk("R8 address kept", v, 32'h4000_1234);

    // R11 fault in ctx3 leaves ctx1 alone
    fault(2'd3, 4'b0001, 3'd1, 2'd1, 32'h0000_0ABC);
    rd(12'h0E0, v); chk("R11 ctx3 status", v, 32'h0000_1101);
    rd(12'h070, v); chk("R11 ctx1 address", v, 32'h4000_1234);

    // R9 clearing
    wr(12'h060, 32'hFFFF_FFFF);
    rd(12'h060, v); chk("R9 nonzero write ignored", v, 32'h0000_2402);
    wr(12'h860, 32'h0);
    rd(12'h060, v); chk("R9 status cleared", v, 0);
    rd(12'h070, v); chk("R9 address zero", v, 0);
    rd(12'h0F0, v); chk("R11 ctx3 address kept", v, 32'h0000_0ABC);
    chk("R10 irq low, ctx3 disabled", irq, 0);
    wr(12'h0C0, 32'h4);
    chk("R10 irq on enable", irq, 1);
    wr(12'h0E0, 32'h0);
    chk("R10 irq after ctx3 clear", irq, 0);

    // R7 zero-flag report ignored
    fault(2'd0, 4'b0000, 3'd4, 2'd1, 32'h0000_9999);
    rd(12'h020, v); chk("R7 empty report status", v, 0);
    rd(12'h030, v); chk("R7 empty report address", v, 0);
    chk("R7 empty report irq", irq, 0);

    // R8 capture after clear
    fault(2'd1, 4'b0001, 3'd0, 2'd0, 32'h0000_0077);
    rd(12'h060, v); chk("R8 recapture status", v, 32'h1);
    rd(12'h070, v); chk("R8 recapture address", v, 32'h77);

    // R1 reset mid-run
    wr(12'h000, 32'h2);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    rd(12'h000, v); chk("R1 ctl after reset", v, 0);
    rd(12'h060, v); chk("R1 status after reset", v, 0);
    chk("R1 flush after reset", flush_req, 0);
    chk("R1 irq after reset", irq, 0);
    chk("R1 mmu_en after reset", ctx_mmu_en, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule